// File: doc/BRIEF.md
# Multichannel ADC Acquisition Sequencer

This block repeatedly collects samples from an external analog input card and hands them to downstream logic. Software controls it through four 32-bit slave registers: a control/status word, two analog output words and a read-only debug word holding the most recent sample. Setting the run bit starts the sequencer. It latches the card's control-register and read-buffer addresses, then writes a trigger command that makes the card buffer every active channel. After that it reads the buffer once per active channel and loops back to trigger again.

All traffic to the card goes through a simple request/acknowledge master port. The card is little-endian and the host is big-endian, so every 32-bit word is byte-reversed on its way in and on its way out. Each sample comes out on a sample port with its channel index and a one-cycle valid strobe. A frame-done strobe marks the last channel of each frame. Clearing the run bit takes effect only at a frame boundary, so a started frame always finishes.

The sequencer has five states. IDLE goes to SETUP once run is set. SETUP always goes to TRIG after one cycle. TRIG goes to READ when the trigger write is acknowledged. READ stays in READ after each non-final read acknowledge. After the final read acknowledge it goes back to TRIG if run is still set, or to PAUSE if run is clear. PAUSE goes to IDLE after one cycle.

Top module: `acq_seq_top`

## Requirements
- R1: After reset: m_req, sample_valid and frame_done are 0, the DAC outputs are 0, and every slave register reads 0.
- R2: Slave offsets 0x4 and 0x8 are read/write and drive dac0_word and dac1_word. Offset 0xC reads {13'b0, channel[18:16], data[15:0]} of the last sample. Writes to 0xC are ignored.
- R3: While the run bit (offset 0x0, bit 8) is clear and the sequencer is in IDLE, no master request is issued.
- R4: The first access after start, and the first access of every frame, is a write to CARD_BASE+BCR_OFS whose data is the byte-reversed host word (1 << TRIG_BIT).
- R5: Once m_req rises, it stays high until m_ack, and m_addr and m_we stay stable.
- R6: Each frame performs exactly N reads from CARD_BASE+BUF_OFS, where N = ctrl[18:16] + 1 is latched at start.
- R7: Each read acknowledge produces sample_valid for one cycle on the next cycle. sample_data is bits 15:0 of the byte-reversed m_rdata, and sample_ch counts 0..N-1 within the frame.
- R8: frame_done pulses for one cycle, together with the sample of channel N-1.
- R9: While run remains set, the trigger of the next frame follows the last read, with no other access between them.
- R10: Clearing run during a frame does not cut the frame short. All N reads complete, then no further request is issued.
- R11: Control bit 0 reads 1 whenever the sequencer is outside IDLE, and 0 in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_wr | input | 1 | Slave write strobe |
| s_addr | input | 4 | Slave byte offset (bits 3:2 select the register) |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data for s_addr |
| m_req | output | 1 | Master access request |
| m_we | output | 1 | Master access is a write |
| m_addr | output | 32 | Master access address |
| m_wdata | output | 32 | Master write data, card byte order |
| m_ack | input | 1 | Card acknowledges the access |
| m_rdata | input | 32 | Card read data, card byte order |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_ch | output | 3 | Channel index of the sample |
| sample_data | output | 16 | Sample value, host order |
| frame_done | output | 1 | One-cycle strobe with the last sample of a frame |
| dac0_word | output | 32 | Analog output word 1 |
| dac1_word | output | 32 | Analog output word 2 |

## Verification
The loop is run with three channel counts: 3, 8 and 1. The count of 1 separates a single-read frame from the back-to-back read path. The count of 8 exercises the full channel index range. The card model varies its acknowledge latency from zero to two wait cycles, which tells a held request apart from one that drops or changes address before the acknowledge. The card returns a distinct value for each frame and channel, so a missed byte reversal, a wrong channel index or a lost sample shows up in the scoreboard. Stop is issued both in the middle of a frame and just after a trigger, which separates a stop honoured at the frame boundary from one that cuts the frame short.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_TRIG,
        ST_READ,
        ST_PAUSE
    } acq_state_t;

    localparam int REG_CTRL = 0;
    localparam int REG_DAC0 = 1;
    localparam int REG_DAC1 = 2;
    localparam int REG_DBG  = 3;

    localparam int CTRL_BUSY_BIT = 0;
    localparam int CTRL_RUN_BIT  = 8;
    localparam int CTRL_CNT_LSB  = 16;

endpackage

// File: rtl/acq_swap.sv
module acq_swap #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end
endmodule

// File: rtl/acq_regbank.sv
module acq_regbank
    import acq_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SW  = 16,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [3:0]     addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic           busy,
    input  logic           smp_valid,
    input  logic [CHW-1:0] smp_ch,
    input  logic [SW-1:0]  smp_data,
    output logic           run,
    output logic [CHW-1:0] cnt_m1,
    output logic [DW-1:0]  dac0,
    output logic [DW-1:0]  dac1
);
    logic [1:0]     widx;
    logic [CHW-1:0] dbg_ch_q;
    logic [SW-1:0]  dbg_data_q;
    logic [DW-1:0]  ctrl_view;
    logic [DW-1:0]  dbg_view;

    assign widx = addr[3:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt_m1 <= '0;
            dac0   <= '0;
            dac1   <= '0;
        end else if (wr) begin
            unique case (widx)
                2'(REG_CTRL): begin
                    run    <= wdata[CTRL_RUN_BIT];
                    cnt_m1 <= wdata[CTRL_CNT_LSB +: CHW];
                end
                2'(REG_DAC0): dac0 <= wdata;
                2'(REG_DAC1): dac1 <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_ch_q   <= '0;
            dbg_data_q <= '0;
        end else if (smp_valid) begin
            dbg_ch_q   <= smp_ch;
            dbg_data_q <= smp_data;
        end
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTRL_BUSY_BIT]          = busy;
        ctrl_view[CTRL_RUN_BIT]           = run;
        ctrl_view[CTRL_CNT_LSB +: CHW]    = cnt_m1;
        dbg_view = '0;
        dbg_view[SW-1:0]                  = dbg_data_q;
        dbg_view[CTRL_CNT_LSB +: CHW]     = dbg_ch_q;
    end

    always_comb begin
        unique case (widx)
            2'(REG_CTRL): rdata = ctrl_view;
            2'(REG_DAC0): rdata = dac0;
            2'(REG_DAC1): rdata = dac1;
            default:      rdata = dbg_view;
        endcase
    end
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
    import acq_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          SW        = 16,
    parameter int          CHW       = 3,
    parameter logic [31:0] CARD_BASE = 32'h4000_0000,
    parameter logic [31:0] BCR_OFS   = 32'h0000_0000,
    parameter logic [31:0] BUF_OFS   = 32'h0000_0020,
    parameter int          TRIG_BIT  = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [CHW-1:0] cnt_m1,
    output logic           m_req,
    output logic           m_we,
    output logic [31:0]    m_addr,
    output logic [DW-1:0]  m_wdata_host,
    input  logic           m_ack,
    input  logic [DW-1:0]  m_rdata_host,
    output logic           smp_valid,
    output logic [CHW-1:0] smp_ch,
    output logic [SW-1:0]  smp_data,
    output logic           frame_done,
    output logic           busy
);
    localparam logic [DW-1:0] TRIG_WORD = DW'(1) << TRIG_BIT;

    acq_state_t     state_q, state_d;
    logic [CHW-1:0] ch_q;
    logic [CHW-1:0] last_q;
    logic [31:0]    bcr_q;
    logic [31:0]    buf_q;
    logic           rd_done;
    logic           last_rd;

    assign rd_done = (state_q == ST_READ) && m_ack;
    assign last_rd = rd_done && (ch_q == last_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_TRIG;
            ST_TRIG:  if (m_ack) state_d = ST_READ;
            ST_READ:  if (last_rd) state_d = run ? ST_TRIG : ST_PAUSE;
            ST_PAUSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            last_q  <= '0;
            bcr_q   <= '0;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETUP) begin
                bcr_q  <= CARD_BASE + BCR_OFS;
                buf_q  <= CARD_BASE + BUF_OFS;
                last_q <= cnt_m1;
            end
            if (state_q == ST_TRIG && m_ack) begin
                ch_q <= '0;
            end else if (rd_done) begin
                ch_q <= ch_q + 1'b1;
            end
        end
    end

    always_comb begin
        m_req        = 1'b0;
        m_we         = 1'b0;
        m_addr       = '0;
        m_wdata_host = '0;
        unique case (state_q)
            ST_TRIG: begin
                m_req        = 1'b1;
                m_we         = 1'b1;
                m_addr       = bcr_q;
                m_wdata_host = TRIG_WORD;
            end
            ST_READ: begin
                m_req  = 1'b1;
                m_addr = buf_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid  <= 1'b0;
            smp_ch     <= '0;
            smp_data   <= '0;
            frame_done <= 1'b0;
        end else begin
            smp_valid  <= rd_done;
            frame_done <= last_rd;
            if (rd_done) begin
                smp_ch   <= ch_q;
                smp_data <= m_rdata_host[SW-1:0];
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/acq_seq_top.sv
module acq_seq_top
    import acq_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          SW        = 16,
    parameter int          MAX_CH    = 8,
    parameter logic [31:0] CARD_BASE = 32'h4000_0000,
    parameter logic [31:0] BCR_OFS   = 32'h0000_0000,
    parameter logic [31:0] BUF_OFS   = 32'h0000_0020,
    parameter int          TRIG_BIT  = 12,
    localparam int         CHW       = $clog2(MAX_CH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_wr,
    input  logic [3:0]     s_addr,
    input  logic [DW-1:0]  s_wdata,
    output logic [DW-1:0]  s_rdata,
    output logic           m_req,
    output logic           m_we,
    output logic [31:0]    m_addr,
    output logic [DW-1:0]  m_wdata,
    input  logic           m_ack,
    input  logic [DW-1:0]  m_rdata,
    output logic           sample_valid,
    output logic [CHW-1:0] sample_ch,
    output logic [SW-1:0]  sample_data,
    output logic           frame_done,
    output logic [DW-1:0]  dac0_word,
    output logic [DW-1:0]  dac1_word
);
    logic           run_w;
    logic           busy_w;
    logic [CHW-1:0] cnt_m1_w;
    logic [DW-1:0]  wdata_host_w;
    logic [DW-1:0]  rdata_host_w;

    acq_regbank #(.DW(DW), .SW(SW), .CHW(CHW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (s_wr),
        .addr      (s_addr),
        .wdata     (s_wdata),
        .rdata     (s_rdata),
        .busy      (busy_w),
        .smp_valid (sample_valid),
        .smp_ch    (sample_ch),
        .smp_data  (sample_data),
        .run       (run_w),
        .cnt_m1    (cnt_m1_w),
        .dac0      (dac0_word),
        .dac1      (dac1_word)
    );

    acq_fsm #(
        .DW(DW), .SW(SW), .CHW(CHW), .CARD_BASE(CARD_BASE),
        .BCR_OFS(BCR_OFS), .BUF_OFS(BUF_OFS), .TRIG_BIT(TRIG_BIT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run_w),
        .cnt_m1       (cnt_m1_w),
        .m_req        (m_req),
        .m_we         (m_we),
        .m_addr       (m_addr),
        .m_wdata_host (wdata_host_w),
        .m_ack        (m_ack),
        .m_rdata_host (rdata_host_w),
        .smp_valid    (sample_valid),
        .smp_ch       (sample_ch),
        .smp_data     (sample_data),
        .frame_done   (frame_done),
        .busy         (busy_w)
    );

    acq_swap #(.DW(DW)) u_swap_wr (.din(wdata_host_w), .dout(m_wdata));
    acq_swap #(.DW(DW)) u_swap_rd (.din(m_rdata),      .dout(rdata_host_w));
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        m_req,
    input logic        m_we,
    input logic [31:0] m_addr,
    input logic        m_ack,
    input logic        busy,
    input logic        run,
    input logic        sample_valid,
    input logic        frame_done
);
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req);

    p_start_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(run));

    p_valid_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(m_req && m_ack && !m_we));

    p_done_with_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> sample_valid);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind acq_seq_top acq_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .m_req        (m_req),
    .m_we         (m_we),
    .m_addr       (m_addr),
    .m_ack        (m_ack),
    .busy         (busy_w),
    .run          (run_w),
    .sample_valid (sample_valid),
    .frame_done   (frame_done)
);

// File: tb/sim_acq_seq_top.sv
`timescale 1ns/1ps
module sim_acq_seq_top;
    localparam logic [31:0] TRIG_ADDR = 32'h4000_0000;
    localparam logic [31:0] BUF_ADDR  = 32'h4000_0020;
    localparam logic [31:0] TRIG_BUS  = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_wr = 1'b0;
    logic [3:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        sample_valid;
    logic [2:0]  sample_ch;
    logic [15:0] sample_data;
    logic        frame_done;
    logic [31:0] dac0_word, dac1_word;

    always #4 clk = ~clk;

    acq_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_rdata(s_rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata),
        .sample_valid(sample_valid), .sample_ch(sample_ch), .sample_data(sample_data),
        .frame_done(frame_done), .dac0_word(dac0_word), .dac1_word(dac1_word)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [18:0] sb_q[$];

    int acc_total = 0;
    int rd_in_frame = 0;
    int exp_n = 1;
    bit first_acc = 1'b0;
    int frame_ctr = 0;
    int done_cnt = 0;
    int wait_c = 0;
    bit ack_q = 1'b0;
    logic [31:0] held_addr;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [31:0] rev32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // card model: variable latency, logs accesses, pushes expected samples
    always @(negedge clk) begin
        if (ack_q) begin
            m_ack <= 1'b0;
            ack_q = 1'b0;
            wait_c = 0;
        end else if (rst_n && m_req) begin
            if (wait_c == 0) held_addr = m_addr;
            else chk(m_addr == held_addr, "R5 addr held", m_addr, held_addr);
            if (wait_c >= acc_total % 3) begin
                if (m_we) begin
                    chk(m_addr == TRIG_ADDR, "R4 trigger addr", m_addr, TRIG_ADDR);
                    chk(m_wdata == TRIG_BUS, "R4 trigger data", m_wdata, TRIG_BUS);
                    if (!first_acc)
                        chk(rd_in_frame == exp_n, "R9 reads before next trigger", rd_in_frame, exp_n);
                    first_acc = 1'b0;
                    rd_in_frame = 0;
                    frame_ctr++;
                end else begin
                    logic [15:0] v;
                    chk(!first_acc, "R4 first access is trigger", 0, 1);
                    chk(m_addr == BUF_ADDR, "R6 read addr", m_addr, BUF_ADDR);
                    chk(rd_in_frame < exp_n, "R6 read count", rd_in_frame, exp_n);
                    v = {frame_ctr[7:0], 5'd0, 3'(rd_in_frame)} ^ 16'h3C00;
                    m_rdata <= rev32({16'hBEEF, v});
                    sb_q.push_back({3'(rd_in_frame), v});
                    rd_in_frame++;
                end
                acc_total++;
                m_ack <= 1'b1;
                ack_q = 1'b1;
            end else begin
                wait_c++;
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 unexpected sample", {13'b0, sample_ch, sample_data}, 0);
            end else begin
                logic [18:0] e;
                e = sb_q.pop_front();
                chk({sample_ch, sample_data} == e, "R7 sample ch/data",
                    {13'b0, sample_ch, sample_data}, {13'b0, e});
            end
        end
        if (rst_n && frame_done) begin
            done_cnt++;
            chk(sample_valid && sample_ch == 3'(exp_n - 1), "R8 done with last channel",
                {28'b0, sample_valid, sample_ch}, {28'b0, 1'b1, 3'(exp_n - 1)});
        end
    end

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        s_wr = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        s_addr = a;
        #1 d = s_rdata;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic start_run(input int n);
        exp_n = n;
        first_acc = 1'b1;
        reg_wr(4'h0, (32'(n - 1) << 16) | 32'h100);
    endtask

    task automatic wait_frames(input int target);
        while (done_cnt < target) @(negedge clk);
    endtask

    task automatic stop_and_check(input int n, input string tag);
        int acc0;
        logic [31:0] d;
        reg_wr(4'h0, 32'(n - 1) << 16);
        wait_frames(done_cnt + 1);
        acc0 = acc_total;
        repeat (40) @(negedge clk);
        chk(acc_total == acc0, {tag, " no access after stop"}, acc_total, acc0);
        chk(rd_in_frame == n, {tag, " frame completed"}, rd_in_frame, n);
        reg_rd(4'h0, d);
        chk(d[0] == 1'b0, "R11 busy clear after stop", d, 0);
        chk(sb_q.size() == 0, "R7 all samples delivered", sb_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!m_req && !sample_valid && !frame_done, "R1 outputs idle",
            {29'b0, m_req, sample_valid, frame_done}, 0);
        chk(dac0_word == 0 && dac1_word == 0, "R1 dac zero", dac0_word | dac1_word, 0);
        for (int i = 0; i < 4; i++) begin
            reg_rd(4'(i * 4), d);
            chk(d == 0, "R1 register zero", d, 0);
        end
        // R2
        reg_wr(4'h4, 32'h1234_5678);
        reg_wr(4'h8, 32'hCAFE_F00D);
        reg_wr(4'hC, 32'hFFFF_FFFF);
        chk(dac0_word == 32'h1234_5678, "R2 dac0 port", dac0_word, 32'h1234_5678);
        chk(dac1_word == 32'hCAFE_F00D, "R2 dac1 port", dac1_word, 32'hCAFE_F00D);
        reg_rd(4'h4, d); chk(d == 32'h1234_5678, "R2 dac0 readback", d, 32'h1234_5678);
        reg_rd(4'h8, d); chk(d == 32'hCAFE_F00D, "R2 dac1 readback", d, 32'hCAFE_F00D);
        reg_rd(4'hC, d); chk(d == 0, "R2 debug write ignored", d, 0);
        // R3: count set but run clear
        reg_wr(4'h0, 32'h0002_0000);
        repeat (20) @(negedge clk);
        chk(acc_total == 0, "R3 no request without run", acc_total, 0);
        reg_rd(4'h0, d);
        chk(d == 32'h0002_0000, "R11 idle status", d, 32'h0002_0000);
        // three channels, stop mid-frame
        start_run(3);
        wait_frames(3);
        reg_rd(4'h0, d);
        chk(d[0] == 1'b1 && d[8] == 1'b1, "R11 busy while running", d, 32'h0002_0101);
        while (rd_in_frame != 1) @(negedge clk);
        stop_and_check(3, "R10 mid-frame stop");
        reg_rd(4'hC, d);
        chk(d[18:16] == 3'd2, "R2 debug channel", d, 32'h0002_0000);
        // eight channels, stop right after a trigger
        start_run(8);
        wait_frames(done_cnt + 2);
        while (!(rd_in_frame == 0 && !first_acc)) @(negedge clk);
        stop_and_check(8, "R10 stop after trigger");
        // single channel
        start_run(1);
        wait_frames(done_cnt + 3);
        stop_and_check(1, "R6 single channel");
        chk(frame_ctr >= 8, "R9 frames looped", frame_ctr, 8);
        summary();
    end
endmodule